// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking a three-level table hierarchy held in memory, so a machine with a 32-bit virtual space can reach a 64 GiB physical space. A requester presents the virtual address together with the current root-pointer register value and the fourth control register. When bit 5 of that control register is clear, translation is off and the address comes back zero-extended one cycle later, with no memory traffic. When the bit is set, the block reads one 64-bit entry per level over a request/valid/ready memory port and returns either the physical address or a page fault tagged with the level that stopped the walk.

The first level is a four-entry pointer table (32-byte aligned, found through the root pointer and indexed by virtual bits [31:30]). The second and third levels are 512-entry tables indexed by virtual bits [29:21] and [20:12]. Each entry address is the table base plus eight times the index. Bit 0 of every entry is the present flag; entry bits [35:12] give the next table base or the final 4 KB frame, and the low 12 virtual bits pass through as the page offset. One translation is handled at a time.

The controller is a four-state machine. `ST_IDLE` (request ready) goes to `ST_FETCH` on an accepted request with translation on, or straight to `ST_REPLY` when it is off. `ST_FETCH` drives the memory read and moves to `ST_AWAIT` when the memory accepts it. `ST_AWAIT` waits for read data, then goes back to `ST_FETCH` for the next level when the entry is present and levels remain, or to `ST_REPLY` on a clear present bit (fault) or on a present last-level entry (result). `ST_REPLY` pulses the response for one cycle and returns to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: With `req_ctl[5]` clear, an accepted request yields `resp_valid` on the cycle after acceptance with `resp_paddr` equal to `{4'b0, req_vaddr}`, `resp_fault` low, and no memory read issued; all other `req_ctl` bits have no effect.
- R2: With `req_ctl[5]` set, the reads go out in this order: `{req_root[31:5],5'b0} + 8*VA[31:30]`, then `D + 8*VA[29:21]`, then `P + 8*VA[20:12]`, where D and P are `{entry[35:12], 12'b0}` of the previous entry read.
- R3: When all three entries are present, the response carries `resp_fault` low, `resp_fault_level` 0 and `resp_paddr = {last_entry[35:12], VA[11:0]}`.
- R4: Entry bits [63:36] and [11:1] have no effect on the addresses read or on the result.
- R5: An entry with bit 0 clear ends the walk with no further read; the response carries `resp_fault` high, `resp_paddr` 0 and `resp_fault_level` 0 for the pointer table, 1 for the directory, 2 for the page table.
- R6: Bits [4:0] of `req_root` have no effect on any read address or result.
- R7: `req_ready` is low from the cycle after acceptance through the single-cycle `resp_valid` pulse, and high again on the next cycle; no memory read is requested while `req_ready` is high.
- R8: A memory read request held without `mem_req_ready` keeps `mem_req_valid` high and `mem_req_addr` unchanged on the next cycle, and at most one read is outstanding.
- R9: During and right after reset, `req_ready` is high while `resp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Root-pointer register value (pointer table base) |
| req_ctl | input | 32 | Fourth control register; bit 5 enables translation |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_paddr | output | 36 | Physical address (0 on fault) |
| resp_fault | output | 1 | Page fault flag |
| resp_fault_level | output | 2 | Level at which the fault occurred |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 36 | Byte address of the 64-bit entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |

## Verification
Translation is exercised with the enable bit clear (with and without every other control bit set), with complete three-level walks, and with a clear present bit placed at each of the three levels, which separates the bypass path from the walk and tells which level stopped it. Entries carry random values in their unused bit ranges and the root pointer carries random low bits, so a design that lets those bits leak shows up as a wrong read address or a wrong frame. Extreme virtual addresses (all zeros, all ones, top bits set) check the index fields at their limits, and a random memory that stalls requests and delays data checks the handshake and the one-at-a-time ordering.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    // Controller states of the walker.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_AWAIT = 2'd2,
        ST_REPLY = 2'd3
    } walk_state_e;

    // Table level being read; the code is also the reported fault level.
    typedef enum logic [1:0] {
        LVL_PTR = 2'd0,
        LVL_DIR = 2'd1,
        LVL_PTE = 2'd2
    } walk_level_e;

    localparam int WALK_LEVELS = 3;

endpackage

// File: rtl/pt_walk_entry.sv
// Splits a fetched table entry into its present flag and frame number.
module pt_walk_entry #(
    parameter int ENT_W    = 64,
    parameter int PA_W     = 36,
    parameter int PG_SHIFT = 12,
    localparam int FRM_W   = PA_W - PG_SHIFT
) (
    input  logic [ENT_W-1:0] entry,
    output logic             present,
    output logic [FRM_W-1:0] frame
);

    // Bits outside the flag and the frame field carry no meaning here.
    logic unused_entry_bits;

    assign present           = entry[0];
    assign frame             = entry[PA_W-1:PG_SHIFT];
    assign unused_entry_bits = ^entry;

endmodule

// File: rtl/pt_walk_idx.sv
// Forms the byte address of the entry to read: table base + index * entry size.
module pt_walk_idx
    import pt_walk_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 36,
    parameter int PG_SHIFT  = 12,
    parameter int IDX_W     = 9,
    parameter int TOP_W     = 2,
    parameter int ENT_W     = 64,
    localparam int VPN_W    = VA_W - PG_SHIFT,
    localparam int ENT_SHIFT = $clog2(ENT_W / 8)
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    input  walk_level_e      level,
    output logic [PA_W-1:0]  addr
);

    logic [PA_W-1:0] lvl_off [WALK_LEVELS];
    logic [PA_W-1:0] sel_off;

    // Level g uses a field starting IDX_W*(levels-1-g) bits above the page offset;
    // the top level uses the narrow pointer-table index.
    for (genvar g = 0; g < WALK_LEVELS; g++) begin : g_lvl
        localparam int LO = IDX_W * (WALK_LEVELS - 1 - g);
        localparam int W  = (g == 0) ? TOP_W : IDX_W;
        assign lvl_off[g] = PA_W'(vpn[LO +: W]) << ENT_SHIFT;
    end

    always_comb begin
        sel_off = lvl_off[0];
        unique case (level)
            LVL_PTR: sel_off = lvl_off[0];
            LVL_DIR: sel_off = lvl_off[1];
            LVL_PTE: sel_off = lvl_off[2];
            default: sel_off = lvl_off[0];
        endcase
    end

    assign addr = base + sel_off;

endmodule

// File: rtl/pt_walk_fsm.sv
// Sequencing of one translation: accept, read level by level, reply.
module pt_walk_fsm
    import pt_walk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        xlate_en,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        ent_present,
    output logic        req_ready,
    output logic        mem_req_valid,
    output logic        resp_valid,
    output walk_level_e level,
    output logic        ld_root,
    output logic        ld_bypass,
    output logic        ld_next,
    output logic        ld_final,
    output logic        ld_fault
);

    walk_state_e state_q, state_d;
    walk_level_e level_d;

    // State and level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level   <= LVL_PTR;
        end else begin
            state_q <= state_d;
            level   <= level_d;
        end
    end

    // Transitions and datapath load strobes.
    always_comb begin
        state_d   = state_q;
        level_d   = level;
        ld_root   = 1'b0;
        ld_bypass = 1'b0;
        ld_next   = 1'b0;
        ld_final  = 1'b0;
        ld_fault  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (xlate_en) begin
                        ld_root = 1'b1;
                        level_d = LVL_PTR;
                        state_d = ST_FETCH;
                    end else begin
                        ld_bypass = 1'b1;
                        state_d   = ST_REPLY;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_req_ready) begin
                    state_d = ST_AWAIT;
                end
            end
            ST_AWAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        ld_fault = 1'b1;
                        state_d  = ST_REPLY;
                    end else if (level == LVL_PTE) begin
                        ld_final = 1'b1;
                        state_d  = ST_REPLY;
                    end else begin
                        ld_next = 1'b1;
                        level_d = (level == LVL_PTR) ? LVL_DIR : LVL_PTE;
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_REPLY: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Handshake outputs follow the state alone.
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        resp_valid    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready     = 1'b1;
            ST_FETCH: mem_req_valid = 1'b1;
            ST_AWAIT: ;
            ST_REPLY: resp_valid    = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/pt_walker.sv
// Three-level address translation walker, top level.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 36,
    parameter int ROOT_W     = 32,
    parameter int CTL_W      = 32,
    parameter int EN_BIT     = 5,
    parameter int ENT_W      = 64,
    parameter int PG_SHIFT   = 12,
    parameter int IDX_W      = 9,
    parameter int TOP_W      = 2,
    parameter int ROOT_ALIGN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [ROOT_W-1:0] req_root,
    input  logic [CTL_W-1:0]  req_ctl,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_paddr,
    output logic              resp_fault,
    output logic [1:0]        resp_fault_level,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data
);

    localparam int FRM_W = PA_W - PG_SHIFT;
    localparam int VPN_W = VA_W - PG_SHIFT;

    walk_level_e      level;
    logic             ld_root, ld_bypass, ld_next, ld_final, ld_fault;
    logic             ent_present;
    logic [FRM_W-1:0] ent_frame;
    logic             xlate_en;
    logic [PA_W-1:0]  root_base;

    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  base_q;
    logic [PA_W-1:0]  paddr_q;
    logic             fault_q;
    logic [1:0]       flvl_q;

    // Only the enable bit and the aligned part of the root pointer matter.
    logic unused_ctl_root;
    assign unused_ctl_root = ^{req_ctl, req_root[ROOT_ALIGN-1:0]};

    assign xlate_en  = req_ctl[EN_BIT];
    assign root_base = PA_W'({req_root[ROOT_W-1:ROOT_ALIGN], {ROOT_ALIGN{1'b0}}});

    pt_walk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .xlate_en      (xlate_en),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_present   (ent_present),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .resp_valid    (resp_valid),
        .level         (level),
        .ld_root       (ld_root),
        .ld_bypass     (ld_bypass),
        .ld_next       (ld_next),
        .ld_final      (ld_final),
        .ld_fault      (ld_fault)
    );

    pt_walk_entry #(
        .ENT_W    (ENT_W),
        .PA_W     (PA_W),
        .PG_SHIFT (PG_SHIFT)
    ) u_entry (
        .entry   (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    pt_walk_idx #(
        .VA_W     (VA_W),
        .PA_W     (PA_W),
        .PG_SHIFT (PG_SHIFT),
        .IDX_W    (IDX_W),
        .TOP_W    (TOP_W),
        .ENT_W    (ENT_W)
    ) u_idx (
        .base  (base_q),
        .vpn   (va_q[VA_W-1:PG_SHIFT]),
        .level (level),
        .addr  (mem_req_addr)
    );

    // Walk datapath: latched request, current table base, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q    <= '0;
            base_q  <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            flvl_q  <= 2'd0;
        end else begin
            if (ld_root || ld_bypass) begin
                va_q <= req_vaddr;
            end
            if (ld_root) begin
                base_q <= root_base;
            end
            if (ld_next) begin
                base_q <= {ent_frame, {PG_SHIFT{1'b0}}};
            end
            if (ld_bypass) begin
                paddr_q <= PA_W'(req_vaddr);
                fault_q <= 1'b0;
                flvl_q  <= 2'd0;
            end
            if (ld_final) begin
                paddr_q <= {ent_frame, va_q[PG_SHIFT-1:0]};
                fault_q <= 1'b0;
                flvl_q  <= 2'd0;
            end
            if (ld_fault) begin
                paddr_q <= '0;
                fault_q <= 1'b1;
                flvl_q  <= level;
            end
        end
    end

    assign resp_paddr       = paddr_q;
    assign resp_fault       = fault_q;
    assign resp_fault_level = flvl_q;

    logic unused_vpn_width;
    assign unused_vpn_width = ^VPN_W;

endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and result properties of the walker, bound onto the top.
module pt_walker_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 36
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            xlate_en,
    input logic            resp_valid,
    input logic [PA_W-1:0] resp_paddr,
    input logic            resp_fault,
    input logic [1:0]      resp_fault_level,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr
);

    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlate_en) |=>
            (resp_valid && !resp_fault && resp_paddr == PA_W'($past(req_vaddr)))); // R1

    AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'd0)); // R2

    AST_DONE_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_fault_level == 2'd0)); // R3

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0 && resp_fault_level != 2'd3)); // R5

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R7

    AST_BUSY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R8

endmodule

bind pt_walker pt_walker_chk #(
    .VA_W (VA_W),
    .PA_W (PA_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .req_vaddr        (req_vaddr),
    .xlate_en         (req_ctl[EN_BIT]),
    .resp_valid       (resp_valid),
    .resp_paddr       (resp_paddr),
    .resp_fault       (resp_fault),
    .resp_fault_level (resp_fault_level),
    .mem_req_valid    (mem_req_valid),
    .mem_req_ready    (mem_req_ready),
    .mem_req_addr     (mem_req_addr)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [31:0] req_root;
    logic [31:0] req_ctl;
    logic        resp_valid;
    logic [35:0] resp_paddr;
    logic        resp_fault;
    logic [1:0]  resp_fault_level;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [35:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    always #4 clk = ~clk; // 125 MHz

    pt_walker u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_ready        (req_ready),
        .req_vaddr        (req_vaddr),
        .req_root         (req_root),
        .req_ctl          (req_ctl),
        .resp_valid       (resp_valid),
        .resp_paddr       (resp_paddr),
        .resp_fault       (resp_fault),
        .resp_fault_level (resp_fault_level),
        .mem_req_valid    (mem_req_valid),
        .mem_req_ready    (mem_req_ready),
        .mem_req_addr     (mem_req_addr),
        .mem_rsp_valid    (mem_rsp_valid),
        .mem_rsp_data     (mem_rsp_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    logic [63:0] mem_tab [logic [35:0]];
    logic [35:0] rd_log [8];
    int          n_rd = 0;

    logic [35:0] exp_addr [3];
    int          exp_n;
    logic        exp_fault;
    logic [1:0]  exp_lvl;
    logic [35:0] exp_pa;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [35:0] a);
        return mem_tab.exists(a) ? mem_tab[a] : 64'd0;
    endfunction

    // Entry with random junk in bits outside the flag and the frame field.
    function automatic logic [63:0] mk(input logic [23:0] fr, input logic p);
        logic [27:0] hi = 28'($urandom);
        logic [10:0] lo = 11'($urandom);
        return {hi, fr, lo, p};
    endfunction

    // Expected outcome from the table contents.
    task automatic model(input logic [31:0] va, input logic [31:0] root, input logic [31:0] ctl);
        logic [35:0] base;
        logic [35:0] a;
        logic [63:0] e;
        logic [35:0] off;
        exp_n = 0; exp_fault = 0; exp_lvl = 0;
        if (!ctl[5]) begin
            exp_pa = {4'b0, va};
            return;
        end
        base = {4'b0, root[31:5], 5'b0};
        for (int lv = 0; lv < 3; lv++) begin
            off = (lv == 0) ? 36'(va[31:30]) : (lv == 1) ? 36'(va[29:21]) : 36'(va[20:12]);
            a = base + (off << 3);
            exp_addr[lv] = a;
            exp_n = lv + 1;
            e = rd(a);
            if (!e[0]) begin
                exp_fault = 1; exp_lvl = 2'(lv); exp_pa = 36'd0;
                return;
            end
            if (lv == 2) exp_pa = {e[35:12], va[11:0]};
            else base = {e[35:12], 12'b0};
        end
    endtask

    task automatic build(input logic [31:0] va, input logic [31:0] root, input logic [2:0] pm);
        logic [23:0] f1 = 24'($urandom);
        logic [23:0] f2 = 24'($urandom);
        logic [23:0] f3 = 24'($urandom);
        logic [35:0] a0, a1, a2;
        mem_tab.delete();
        a0 = {4'b0, root[31:5], 5'b0} + (36'(va[31:30]) << 3);
        mem_tab[a0] = mk(f1, pm[0]);
        if (pm[0]) begin
            a1 = {f1, 12'b0} + (36'(va[29:21]) << 3);
            mem_tab[a1] = mk(f2, pm[1]);
            if (pm[1]) begin
                a2 = {f2, 12'b0} + (36'(va[20:12]) << 3);
                mem_tab[a2] = mk(f3, pm[2]);
            end
        end
    endtask

    // One translation, checked end to end.
    task automatic run(input logic [31:0] va, input logic [31:0] root, input logic [31:0] ctl);
        int cyc;
        model(va, root, ctl);
        n_rd = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_root = root; req_ctl = ctl;
        @(negedge clk);
        req_valid = 0; req_vaddr = $urandom; req_root = $urandom; req_ctl = $urandom;
        chk(!req_ready, "R7 ready low after accept", 64'(req_ready), 64'd0);
        cyc = 1;
        while (!resp_valid && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        if (!ctl[5]) begin
            chk(cyc == 1, "R1 bypass latency", 64'(cyc), 64'd1);
            chk(n_rd == 0, "R1 no reads", 64'(n_rd), 64'd0);
        end
        chk(resp_valid === 1'b1, "R7 response seen", 64'(resp_valid), 64'd1);
        chk(resp_fault === exp_fault, exp_fault ? "R5 fault flag" : "R3 fault flag",
            64'(resp_fault), 64'(exp_fault));
        chk(resp_paddr === exp_pa, exp_fault ? "R5 paddr" : (ctl[5] ? "R3 R4 R6 paddr" : "R1 paddr"),
            64'(resp_paddr), 64'(exp_pa));
        chk(resp_fault_level === exp_lvl, "R5 fault level", 64'(resp_fault_level), 64'(exp_lvl));
        chk(n_rd == exp_n, "R2 R5 read count", 64'(n_rd), 64'(exp_n));
        for (int i = 0; i < exp_n && i < n_rd; i++)
            chk(rd_log[i] === exp_addr[i], "R2 R4 R6 read address", 64'(rd_log[i]), 64'(exp_addr[i]));
        @(negedge clk);
        chk(!resp_valid && req_ready, "R7 back to idle", {62'd0, resp_valid, req_ready}, 64'd1);
    endtask

    // Memory model: random acceptance stalls and data latency.
    initial begin : mem_side
        bit          pend = 0;
        int          lat = 0;
        logic [35:0] pa = '0;
        bit          was_stall = 0;
        logic [35:0] stall_addr = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (rst_n) begin
                if (was_stall)
                    chk(mem_req_valid && mem_req_addr == stall_addr, "R8 request held",
                        64'(mem_req_addr), 64'(stall_addr));
                was_stall = 0;
                if (pend) begin
                    mem_req_ready = 0;
                    if (lat == 0) begin
                        mem_rsp_valid = 1;
                        mem_rsp_data  = rd(pa);
                        pend = 0;
                    end else lat--;
                end else if (mem_req_valid) begin
                    if ($urandom % 3 != 0) begin
                        mem_req_ready = 1;
                        if (n_rd < 8) rd_log[n_rd] = mem_req_addr;
                        n_rd++;
                        pa = mem_req_addr;
                        pend = 1;
                        lat = $urandom % 3;
                    end else begin
                        mem_req_ready = 0;
                        was_stall = 1;
                        stall_addr = mem_req_addr;
                    end
                end else begin
                    mem_req_ready = 0;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] va, root, ctl;
        logic [2:0]  pm;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; req_valid = 0; req_vaddr = '0; req_root = '0; req_ctl = '0;
        repeat (3) @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req_valid, "R9 in reset",
            {61'd0, req_ready, resp_valid, mem_req_valid}, 64'd4);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !mem_req_valid, "R9 after reset",
            {61'd0, req_ready, resp_valid, mem_req_valid}, 64'd4);

        // Directed corner cases.
        mem_tab.delete();
        run(32'hDEAD_BEEF, 32'h0001_2000, 32'h0000_0000);              // R1
        run(32'hFFFF_FFFF, 32'h0001_2000, 32'hFFFF_FFDF);              // R1 other bits set
        build(32'h1234_5678, 32'h0ABC_D000, 3'b111);
        run(32'h1234_5678, 32'h0ABC_D000, 32'h0000_0020);              // R2 R3
        build(32'h8765_4321, 32'h0ABC_D000, 3'b000);
        run(32'h8765_4321, 32'h0ABC_D000, 32'h0000_0020);              // R5 level 0
        build(32'h4444_3210, 32'h0000_3000, 3'b001);
        run(32'h4444_3210, 32'h0000_3000, 32'h0000_0020);              // R5 level 1
        build(32'hC0FF_EE12, 32'h7777_7000, 3'b011);
        run(32'hC0FF_EE12, 32'h7777_7000, 32'h0000_0020);              // R5 level 2
        build(32'hC000_0FFF, 32'h0000_101F, 3'b111);
        run(32'hC000_0FFF, 32'h0000_101F, 32'h0000_0020);              // R6
        build(32'h0000_0000, 32'h0000_0000, 3'b111);
        run(32'h0000_0000, 32'h0000_0000, 32'h0000_0020);
        build(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b111);
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

        // Constrained random walks.
        for (int t = 0; t < 300; t++) begin
            va   = $urandom;
            root = $urandom;
            ctl  = $urandom;
            ctl[5] = ($urandom % 5 != 0);
            pm   = ($urandom % 10 < 7) ? 3'b111 : 3'($urandom);
            build(va, root, pm);
            run(va, root, ctl);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule